// File: doc/BRIEF.md
# Strobe-Clocked Circular Memory Streamer

This block sends the whole contents of a 128-byte memory as an endless serial stream on one open-drain data line. It has no addressing and no handshake. Each rising edge of a slow, free-running strobe input moves the stream on by one bit. Each byte goes out as a nine-slot frame: eight data bits, most significant first, then one released (null) slot. After the last location the stream goes back to location zero and keeps going.

After reset the block waits out a silent window of nine strobe edges before it drives anything. It reads bytes from an external synchronous read port, one byte per frame, and fetches each byte during the null slot before it is needed. A mode controller enables the block only while the system is in transmit-only operation. The bidirectional-bus clock line must also be high for the stream to run. A restart input puts the pointer back to zero without repeating the silent window.

The strobe and the bus clock line are asynchronous. Both are synchronised into the system clock, and the strobe is edge-detected there.

Top module: `vstream_tx`

## Requirements
- R1: While reset is high and in the first cycle after it, `sda_pull` and `active` are 0 and `mem_addr` is 0.
- R2: For the first nine strobe rising edges after reset, `sda_pull` stays 0 (line released) and `active` stays 0.
- R3: The tenth strobe rising edge after reset presents bit 7 of the byte at address 0, and `active` becomes 1.
- R4: Each later strobe edge presents the next bit of the current byte, bit 7 down to bit 0. A 0 bit asserts `sda_pull`; a 1 bit leaves the line released.
- R5: The ninth slot of every frame is released (`sda_pull` = 0), and the edge after it presents bit 7 of the next address.
- R6: The byte after address 127 is address 0, and the stream continues without limit.
- R7: While the synchronised `scl_in` is low, `sda_pull` and `active` are 0 and strobe edges do not advance the stream. After `scl_in` returns high, the next edge presents the slot that follows the last one shown.
- R8: While `enable` is low, the behaviour is the same as in R7.
- R9: A `restart` pulse sets the address to 0 and releases the line. The next strobe edge presents bit 7 of address 0, with no silent window, even when the pulse arrives during the post-reset window.
- R10: If `restart` and a detected strobe edge fall in the same cycle, the restart takes effect and the strobe edge is dropped.
- R11: Each byte is read exactly once. `mem_rd_en` is high for one cycle with `mem_addr` set to the next byte's address, at the start of the null slot, at the end of the silent window, or on a restart. `mem_rd_data` is taken one cycle later.
- R12: `sda_pull` changes on the third system clock rising edge after the strobe input rises. The strobe's high and low phases must each last at least three system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | High while the mode controller is in transmit-only operation |
| vclk_in | input | 1 | Asynchronous stream strobe |
| scl_in | input | 1 | Asynchronous level of the bidirectional-bus clock line |
| restart | input | 1 | Reload the pointer to address 0 |
| mem_rd_data | input | 8 | Read data, valid one cycle after `mem_rd_en` |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 7 | Memory read address |
| sda_pull | output | 1 | Pull-down enable for the open-drain data line |
| active | output | 1 | High while data frames are being driven |

## Verification
Two functions can land in the same cycle: a `restart` and the internal pulse made by a strobe edge. The bench places the restart exactly in the cycle where that pulse is sampled, which is the third clock edge after the strobe rises. It then requires that the line stays released for that strobe edge and that the next edge presents bit 7 of address 0. The latency of that next edge is also counted to the exact clock: the bench sees the old level on the second edge and the new level on the third.

// File: rtl/vs_pkg.sv
package vs_pkg;
  typedef enum logic [1:0] {
    ST_SYNC = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/vs_sync.sv
module vs_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst)
          chain[s] <= RST_VAL;
        else if (s == 0)
          chain[s] <= d_async;
        else
          chain[s] <= chain[(s > 0) ? s-1 : 0];
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/vs_edge.sv
module vs_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/vs_seq.sv
module vs_seq
  import vs_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int SYNC_EDGES = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gate,
  input  logic              tick,
  input  logic              restart,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] addr,
  output logic              sda_pull,
  output logic              active
);
  localparam int POS_W = $clog2(DATA_W + 1);
  localparam int CNT_W = $clog2(SYNC_EDGES + 1);
  localparam logic [POS_W-1:0] NULL_POS = POS_W'(DATA_W);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(SYNC_EDGES - 1);

  seq_state_t        st_q, st_n;
  logic [POS_W-1:0]  pos_q, pos_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              pull_q, pull_n;
  logic              rd_q, rd_n;
  logic              fetch_q;
  logic              act_q, act_n;

  always_comb begin
    st_n   = st_q;
    pos_n  = pos_q;
    cnt_n  = cnt_q;
    ptr_n  = ptr_q;
    sh_n   = fetch_q ? rd_data : sh_q;
    pull_n = pull_q;
    rd_n   = 1'b0;
    if (restart) begin
      st_n   = ST_ARM;
      ptr_n  = '0;
      pos_n  = NULL_POS;
      pull_n = 1'b0;
      rd_n   = 1'b1;
    end else if (!gate) begin
      pull_n = 1'b0;
    end else if (tick) begin
      case (st_q)
        ST_SYNC: begin
          pull_n = 1'b0;
          if (cnt_q == SYNC_END) begin
            st_n = ST_ARM;
            rd_n = 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: begin
          if (st_q == ST_ARM || pos_q == NULL_POS) begin
            st_n   = ST_RUN;
            pull_n = ~sh_q[DATA_W-1];
            sh_n   = sh_q << 1;
            pos_n  = '0;
          end else if (pos_q == LAST_POS) begin
            pull_n = 1'b0;
            pos_n  = NULL_POS;
            ptr_n  = ptr_q + 1'b1;
            rd_n   = 1'b1;
          end else begin
            pull_n = ~sh_q[DATA_W-1];
            sh_n   = sh_q << 1;
            pos_n  = pos_q + 1'b1;
          end
        end
      endcase
    end
    act_n = gate && !restart && (st_n == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_SYNC;
      pos_q   <= NULL_POS;
      cnt_q   <= '0;
      ptr_q   <= '0;
      sh_q    <= '0;
      pull_q  <= 1'b0;
      rd_q    <= 1'b0;
      fetch_q <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      pos_q   <= pos_n;
      cnt_q   <= cnt_n;
      ptr_q   <= ptr_n;
      sh_q    <= sh_n;
      pull_q  <= pull_n;
      rd_q    <= rd_n;
      fetch_q <= rd_q;
      act_q   <= act_n;
    end
  end

  assign rd_en    = rd_q;
  assign addr     = ptr_q;
  assign sda_pull = pull_q;
  assign active   = act_q;

  // R2
  sync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SYNC) |-> (!pull_q && !act_q));

  // R11
  fetch_slot_chk: assert property (@(posedge clk) disable iff (rst)
    rd_q |-> (st_q == ST_ARM || pos_q == NULL_POS));

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_q != $past(ptr_q)) |-> (ptr_q == $past(ptr_q) + 1'b1 || ptr_q == '0));

  // R4
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    pos_q <= NULL_POS);

  // R10
  restart_wins_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (st_q == ST_ARM && ptr_q == '0 && !pull_q));
endmodule

// File: rtl/vstream_tx.sv
module vstream_tx #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_EDGES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              vclk_in,
  input  logic              scl_in,
  input  logic              restart,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              sda_pull,
  output logic              active
);
  logic [1:0] pins_s;
  logic       tick;
  logic       gate;

  vs_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b10)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async({scl_in, vclk_in}),
    .d_sync (pins_s)
  );

  vs_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .level(pins_s[0]),
    .rise (tick)
  );

  assign gate = enable & pins_s[1];

  vs_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SYNC_EDGES(SYNC_EDGES)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .gate    (gate),
    .tick    (tick),
    .restart (restart),
    .rd_data (mem_rd_data),
    .rd_en   (mem_rd_en),
    .addr    (mem_addr),
    .sda_pull(sda_pull),
    .active  (active)
  );

  // R7
  scl_low_release_chk: assert property (@(posedge clk) disable iff (rst)
    !pins_s[1] |=> (!sda_pull && !active));

  // R8
  enable_low_release_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!sda_pull && !active));
endmodule

// File: tb/vstream_tx_bench.sv
module vstream_tx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b1;
  logic       vclk_in = 1'b0;
  logic       scl_in = 1'b1;
  logic       restart = 1'b0;
  logic [7:0] mem_rd_data = 8'h00;
  logic       mem_rd_en;
  logic [6:0] mem_addr;
  logic       sda_pull;
  logic       active;

  int n_tests = 0;
  int n_fail  = 0;
  int rd_count = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vstream_tx u_vstream_tx (
    .clk(clk), .rst(rst), .enable(enable), .vclk_in(vclk_in), .scl_in(scl_in),
    .restart(restart), .mem_rd_data(mem_rd_data), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .sda_pull(sda_pull), .active(active)
  );

  function automatic logic [7:0] memval(input int a);
    return 8'((a % 128) * 37 + 11);
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= memval(int'(mem_addr));
      rd_count <= rd_count + 1;
    end
  end

  function automatic logic line();
    return sda_pull ? 1'b0 : 1'b1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk); vclk_in = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic unpulse();
    vclk_in = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic step_check(input logic exp, input string tag);
    pulse();
    check(line() == exp, tag, line(), exp);
    unpulse();
  endtask

  task automatic frame_bits(input int a, input int from_bit, input int to_bit, input string tag);
    for (int b = from_bit; b >= to_bit; b--) step_check(memval(a)[b], tag);
  endtask

  task automatic null_slot(input int next_a, input string tag);
    step_check(1'b1, tag);
    check(mem_addr == 7'(next_a % 128), {tag, " addr"}, mem_addr, next_a % 128);
  endtask

  task automatic do_reset();
    rst = 1'b1; vclk_in = 1'b0; restart = 1'b0; enable = 1'b1; scl_in = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(!sda_pull && !active && mem_addr == 0, "R1 in reset", {sda_pull, active}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!sda_pull && !active && mem_addr == 0, "R1 after reset", {sda_pull, active}, 0);
  endtask

  task automatic t_sync_window();
    for (int i = 0; i < 9; i++) begin
      pulse();
      check(line() == 1'b1 && !active, "R2 silent window", {line(), active}, 2);
      unpulse();
    end
  endtask

  task automatic t_first_frame();
    int r0;
    r0 = rd_count;
    pulse();
    check(line() == memval(0)[7], "R3 tenth edge msb", line(), memval(0)[7]);
    check(active == 1'b1, "R3 active", active, 1);
    unpulse();
    frame_bits(0, 6, 0, "R4 byte0 bits");
    null_slot(1, "R5 null slot");
    repeat (3) @(negedge clk);
    check(rd_count - r0 == 1, "R11 one read per byte", rd_count - r0, 1);
  endtask

  task automatic t_stream_wrap();
    for (int a = 1; a < 128; a++) begin
      frame_bits(a, 7, 0, "R4 stream bits");
      null_slot(a + 1, "R6 pointer step");
    end
    frame_bits(0, 7, 0, "R6 wrap byte0");
    null_slot(1, "R5 null after wrap");
  endtask

  task automatic t_scl_gate();
    frame_bits(1, 7, 5, "R7 pre-gate bits");
    @(negedge clk); scl_in = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      pulse();
      check(line() == 1'b1 && !active, "R7 scl low released", {line(), active}, 2);
      unpulse();
    end
    scl_in = 1'b1;
    repeat (4) @(negedge clk);
    frame_bits(1, 4, 0, "R7 resumed slot");
    null_slot(2, "R7 null");
  endtask

  task automatic t_enable_gate();
    frame_bits(2, 7, 4, "R8 pre-gate bits");
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    check(!sda_pull && !active, "R8 enable low released", {sda_pull, active}, 0);
    for (int i = 0; i < 3; i++) begin
      pulse();
      check(line() == 1'b1, "R8 edges ignored", line(), 1);
      unpulse();
    end
    enable = 1'b1;
    @(negedge clk);
    frame_bits(2, 3, 0, "R8 resumed slot");
    null_slot(3, "R8 null");
  endtask

  task automatic t_restart_timed();
    frame_bits(3, 7, 6, "R9 pre-restart bits");
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    @(negedge clk);
    check(line() == 1'b1 && !active && mem_addr == 0, "R9 restart releases", {line(), active}, 2);
    vclk_in = 1'b1;
    @(negedge clk); @(negedge clk);
    check(line() == 1'b1, "R12 old level at second edge", line(), 1);
    @(negedge clk);
    check(line() == memval(0)[7], "R12 new level at third edge", line(), memval(0)[7]);
    repeat (2) @(negedge clk);
    unpulse();
    frame_bits(0, 6, 0, "R9 byte0 after restart");
    null_slot(1, "R9 null");
  endtask

  task automatic t_collide();
    frame_bits(1, 7, 5, "R10 pre bits");
    @(negedge clk); vclk_in = 1'b1;
    @(negedge clk);
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    repeat (2) @(negedge clk);
    check(line() == 1'b1 && !active, "R10 edge dropped", line(), 1);
    unpulse();
    frame_bits(0, 7, 0, "R10 byte0 after collide");
  endtask

  task automatic t_restart_in_sync();
    do_reset();
    for (int i = 0; i < 3; i++) step_check(1'b1, "R2 window before restart");
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    repeat (3) @(negedge clk);
    step_check(memval(0)[7], "R9 no second window");
    frame_bits(0, 6, 0, "R9 byte0 bits");
  endtask

  initial begin
    t_reset();
    t_sync_window();
    t_first_frame();
    t_stream_wrap();
    t_scl_gate();
    t_enable_gate();
    t_restart_timed();
    t_collide();
    t_restart_in_sync();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule